// File: doc/BRIEF.md
# Sub-Range Stepping ADC Resolution Extender

This controller drives an external 8-bit converter whose input first passes through an analog summing stage. Three select outputs each switch a fixed offset into that stage, and each offset moves the converter's window to a different quarter of the input span. Each sample starts with no offset applied. When a result comes back at full scale, the controller moves to the next quarter and converts again. The fourth quarter is taken as it comes. The sample's 10-bit value is the quarter index in the two upper bits, above the final 8-bit code.

The host side uses a start request, a busy level and a one-cycle valid pulse with a held result. The converter side uses a one-cycle start pulse, a one-cycle done strobe and an 8-bit data bus. Every converter start follows a programmable settling wait, so the summing stage can recover after a select change.

The state machine has four states. IDLE waits for a start request. SETTLE runs the settling timer. LAUNCH issues the converter start. WAIT_DONE waits for the done strobe. The transitions are:
- IDLE→SETTLE when a request is accepted.
- SETTLE→LAUNCH when the timer expires.
- LAUNCH→WAIT_DONE unconditionally.
- WAIT_DONE→SETTLE on a saturated code in a quarter that is not the last one (this is the step).
- WAIT_DONE→IDLE on any other code, which stores the result.

Top module: `adc_range_stepper`

## Requirements
- R1: A synchronous reset clears the busy level, the valid pulse, the 10-bit result, all three selects and the converter start output.
- R2: An accepted start request raises busy in the next cycle. The first conversion of every sample runs with `sel_o` = 3'b000.
- R3: A code of 8'hFF from any quarter except the last moves the selects to the next quarter and converts again. The `sel_o[2:0]` patterns for quarters 0, 1, 2 and 3 are 000, 100, 010 and 001. At most one select is ever high.
- R4: Any code other than 8'hFF ends the sample. The result is {quarter index[1:0], code[7:0]}.
- R5: A code from quarter 3 (`sel_o` = 001) is accepted even when it is 8'hFF, which gives 10'h3FF.
- R6: `adc_start` is a pulse of exactly one cycle. It comes no earlier than SETTLE_CYCLES cycles after the last change of `sel_o`.
- R7: `adc_code` is taken only in the cycle where `adc_done` is high. Its value in any other cycle has no effect.
- R8: Busy stays high from acceptance until the result is stored. A start request that arrives while busy is ignored: it causes no conversion and leaves the result unchanged.
- R9: `result_valid` is high for exactly one cycle per sample. `result` holds its value between samples.
- R10: When a sample ends, all selects return to 0 whatever quarter succeeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Request for one sample, sampled while idle |
| busy | output | 1 | High while a sample is in progress |
| result_valid | output | 1 | One-cycle pulse when a new result is stored |
| result | output | 10 | Quarter index (upper 2 bits) above the accepted code |
| sel_o | output | 3 | Offset selects, [2] = first step, [0] = last step |
| adc_start | output | 1 | One-cycle converter start pulse |
| adc_done | input | 1 | One-cycle converter completion strobe |
| adc_code | input | 8 | Converter data, valid with adc_done |

## Verification
The bench models the summing stage and converter as a level from 0 to 1023 minus 256 per quarter, clipped to 0..255. The converter model drives 8'hFF on every cycle except the done cycle. Each sample level tests something different:
- Levels inside each of the four quarters separate stepping that happens too early or too late, and a wrong index in the upper result bits.
- The full-scale level shows that a saturated code from the last quarter is accepted.
- A level of exactly 255 shows that a saturated code triggers a step even when the next quarter then returns 0.

Requests sent in the middle of a sample, and a reset applied during a sample, test busy gating and the clearing of the state.

// File: rtl/rsx_pkg.sv
package rsx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_LAUNCH,
        ST_WAIT_DONE
    } rsx_state_e;
endpackage

// File: rtl/rsx_settle_timer.sv
module rsx_settle_timer #(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(SETTLE_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rsx_sel_decode.sv
module rsx_sel_decode #(
    parameter int NUM_RANGES = 4,
    parameter int IDX_W      = 2
) (
    input  logic [IDX_W-1:0]      idx,
    output logic [NUM_RANGES-2:0] sel
);
    // quarter g drives select bit NUM_RANGES-1-g; quarter 0 drives none
    for (genvar g = 1; g < NUM_RANGES; g++) begin : g_sel
        assign sel[NUM_RANGES-1-g] = (idx == IDX_W'(g));
    end
endmodule

// File: rtl/rsx_result_reg.sv
module rsx_result_reg #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             store,
    input  logic [RES_W-1:0] data_in,
    output logic [RES_W-1:0] result,
    output logic             valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= store;
            if (store) begin
                result <= data_in;
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(result)); // R9
endmodule

// File: rtl/adc_range_stepper.sv
module adc_range_stepper
    import rsx_pkg::*;
#(
    parameter int CODE_W        = 8,
    parameter int NUM_RANGES    = 4,
    parameter int SETTLE_CYCLES = 4
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         start_req,
    output logic                                         busy,
    output logic                                         result_valid,
    output logic [CODE_W+$clog2(NUM_RANGES)-1:0]         result,
    output logic [NUM_RANGES-2:0]                        sel_o,
    output logic                                         adc_start,
    input  logic                                         adc_done,
    input  logic [CODE_W-1:0]                            adc_code
);
    localparam int IDX_W = $clog2(NUM_RANGES);
    localparam int RES_W = CODE_W + IDX_W;
    localparam int SEL_W = NUM_RANGES - 1;
    localparam int QW    = $clog2(SETTLE_CYCLES + 1);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_RANGES - 1);
    localparam logic [CODE_W-1:0] SAT_CODE = {CODE_W{1'b1}};

    rsx_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             timer_load;
    logic             timer_expired;
    logic             store;

    rsx_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .expired (timer_expired)
    );

    rsx_sel_decode #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) u_dec (
        .idx (idx_q),
        .sel (sel_o)
    );

    rsx_result_reg #(.RES_W(RES_W)) u_res (
        .clk     (clk),
        .rst     (rst),
        .store   (store),
        .data_in ({idx_q, adc_code}),
        .result  (result),
        .valid   (result_valid)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state
    always_comb begin
        state_d    = state_q;
        idx_d      = idx_q;
        timer_load = 1'b0;
        store      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    idx_d      = '0;
                    timer_load = 1'b1;
                    state_d    = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (timer_expired) begin
                    state_d = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                state_d = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (adc_done) begin
                    if (adc_code == SAT_CODE && idx_q != LAST_IDX) begin
                        idx_d      = idx_q + 1'b1;
                        timer_load = 1'b1;
                        state_d    = ST_SETTLE;
                    end else begin
                        store   = 1'b1;
                        idx_d   = '0;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        adc_start = (state_q == ST_LAUNCH);
    end

    // cycles since the last select change, saturating; used by the checks
    logic [SEL_W-1:0] sel_prev_q;
    logic [QW-1:0]    quiet_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_prev_q <= '0;
            quiet_q    <= '0;
        end else begin
            sel_prev_q <= sel_o;
            if (sel_o != sel_prev_q) begin
                quiet_q <= '0;
            end else if (quiet_q != QW'(SETTLE_CYCLES)) begin
                quiet_q <= quiet_q + 1'b1;
            end
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !result_valid && sel_o == '0)); // R1
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o)); // R3
    AST_STEP_ORDER: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && sel_o != $past(sel_o)) |->
        (sel_o == (($past(sel_o) == '0) ? {1'b1, {(SEL_W-1){1'b0}}} : ($past(sel_o) >> 1)))); // R3
    AST_LAST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_DONE && adc_done && idx_q == LAST_IDX) |=> result_valid); // R5
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start); // R6
    AST_SETTLE_WAIT: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> (quiet_q == QW'(SETTLE_CYCLES))); // R6
    AST_BUSY_TO_VALID: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> result_valid); // R8
    AST_IDLE_SEL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sel_o == '0)); // R10
endmodule

// File: tb/adc_range_stepper_tb.sv
module adc_range_stepper_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int ADC_LAT    = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic       busy, result_valid, adc_start;
    logic [9:0] result;
    logic [2:0] sel_o;
    logic       adc_done = 1'b0;
    logic [7:0] adc_code = 8'hFF;

    int checks = 0;
    int fails  = 0;

    int vin = 0;
    int conv_count = 0;
    logic [2:0] seen_sel [8];
    int lat = 0;
    int cur_k = 0;
    int quiet = 0;
    logic [2:0] prev_sel = 3'b000;
    logic prev_start = 1'b0;

    adc_range_stepper #(.CODE_W(8), .NUM_RANGES(4), .SETTLE_CYCLES(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .start_req(start_req), .busy(busy),
        .result_valid(result_valid), .result(result), .sel_o(sel_o),
        .adc_start(adc_start), .adc_done(adc_done), .adc_code(adc_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model_code(input int level, input int k);
        int v = level - 256 * k;
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return v;
    endfunction

    function automatic logic [2:0] pattern(input int k);
        case (k)
            0: return 3'b000;
            1: return 3'b100;
            2: return 3'b010;
            default: return 3'b001;
        endcase
    endfunction

    // behavioural converter; data bus shows 8'hFF except on the done cycle (R7)
    always @(negedge clk) begin
        if (rst) begin
            adc_done = 1'b0;
            adc_code = 8'hFF;
            lat = 0;
            quiet = 0;
            prev_sel = sel_o;
            prev_start = 1'b0;
        end else begin
            adc_done = 1'b0;
            adc_code = 8'hFF;
            if (sel_o != prev_sel) quiet = 0; else quiet++;
            prev_sel = sel_o;
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    adc_done = 1'b1;
                    adc_code = 8'(model_code(vin, cur_k));
                end
            end
            if (adc_start) begin
                check(!prev_start, "R6", "start pulse width", 2, 1);
                check(quiet >= SETTLE, "R6", "settle cycles before start", quiet, SETTLE);
                if (conv_count < 8) seen_sel[conv_count] = sel_o;
                conv_count++;
                case (sel_o)
                    3'b000: cur_k = 0;
                    3'b100: cur_k = 1;
                    3'b010: cur_k = 2;
                    3'b001: cur_k = 3;
                    default: begin
                        cur_k = 3;
                        check(1'b0, "R3", "illegal select pattern", int'(sel_o), 0);
                    end
                endcase
                lat = ADC_LAT;
            end
            prev_start = adc_start;
        end
    end

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        check(result_valid == 1'b0, "R1", "valid in reset", int'(result_valid), 0);
        check(result == 10'd0, "R1", "result in reset", int'(result), 0);
        check(sel_o == 3'b000, "R1", "selects in reset", int'(sel_o), 0);
        check(adc_start == 1'b0, "R1", "adc_start in reset", int'(adc_start), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_sample(input int level);
        int k = 0;
        int exp;
        int n = 0;
        bit early_drop = 1'b0;
        logic [9:0] held;
        while (k < 3 && model_code(level, k) == 255) k++;
        exp = k * 256 + model_code(level, k);
        vin = level;
        conv_count = 0;
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check(busy == 1'b1, "R2", "busy after accepted request", int'(busy), 1);
        while (!result_valid && n < 1000) begin
            if (!busy) early_drop = 1'b1;
            @(negedge clk);
            n++;
        end
        check(!early_drop, "R8", "busy held until result", 0, 1);
        check(result_valid == 1'b1, "R9", "valid pulse seen", int'(result_valid), 1);
        check(result == 10'(exp), "R4 R5 R7", $sformatf("result for level %0d", level), int'(result), exp);
        check(conv_count == k + 1, "R3", "conversions per sample", conv_count, k + 1);
        for (int i = 0; i <= k && i < 8; i++) begin
            check(seen_sel[i] == pattern(i), "R2 R3", $sformatf("select pattern of conversion %0d", i),
                  int'(seen_sel[i]), int'(pattern(i)));
        end
        check(sel_o == 3'b000, "R10", "selects cleared at completion", int'(sel_o), 0);
        check(busy == 1'b0, "R8", "busy low with valid", int'(busy), 0);
        held = result;
        @(negedge clk);
        check(result_valid == 1'b0, "R9", "valid lasts one cycle", int'(result_valid), 0);
        repeat (3) @(negedge clk);
        check(result == held, "R9", "result held between samples", int'(result), int'(held));
    endtask

    task automatic t_quarters();
        run_sample(100);   // quarter 0
        run_sample(300);   // quarter 1
        run_sample(600);   // quarter 2
        run_sample(900);   // quarter 3
        run_sample(1023);  // R5: saturated last quarter accepted
        run_sample(255);   // saturation at the quarter edge steps to quarter 1
        run_sample(0);
    endtask

    task automatic t_busy_ignore();
        int n = 0;
        logic [9:0] held;
        vin = 700;
        conv_count = 0;
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (5) @(negedge clk);
        start_req = 1'b1;             // request while busy
        @(negedge clk);
        start_req = 1'b0;
        repeat (9) @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        while (!result_valid && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(result == 10'd700, "R8", "result with requests while busy", int'(result), 700);
        held = result;
        repeat (30) @(negedge clk);
        check(busy == 1'b0, "R8", "no sample from ignored request", int'(busy), 0);
        check(conv_count == 3, "R8", "conversion count with ignored requests", conv_count, 3);
        check(result == held, "R8", "result unchanged after ignored request", int'(result), int'(held));
    endtask

    task automatic t_reset_mid();
        vin = 900;
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (12) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(sel_o == 3'b000, "R1", "selects after mid-sample reset", int'(sel_o), 0);
        check(busy == 1'b0, "R1", "busy after mid-sample reset", int'(busy), 0);
        check(result == 10'd0, "R1", "result after mid-sample reset", int'(result), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        run_sample(450);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_quarters();
        t_busy_ignore();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule